// File: doc/BRIEF.md
# Serial Audio DAC Stream Generator

This block drives the serial audio port of a codec from a single master clock. It divides the master clock into a bit clock and a left/right channel-select clock. It then shifts a 16-bit sample out on the DAC data line, most significant bit first. The sample is either of two internally computed 18-bit source values, taken without their two least significant bits. A 2-bit select input picks the source. The codec's ADC serial input can also be looped straight back to the DAC output.

After reset the block stays idle for a programmable number of master-clock cycles. This gives the codec time to be configured over its control port before any serial clocks appear. Once this startup window has expired the block runs freely until the next reset. Sample values are captured at word boundaries, so a source that changes in the middle of a word cannot corrupt the bits already being shifted.

Top module: `audio_dac_stream`

## Requirements
- R1: While rst_ni is low, bclk_o is 0, both channel-select outputs are 1, and the captured samples are zero, so dac_dat_o is 0 for select 01 or 10.
- R2: After rst_ni rises, the serial clocks stay idle (bclk_o 0, channel select 1) until the DELAY_CYC-th rising clk_i edge. The block runs from that edge on and never stops again before the next reset.
- R3: Once running, bclk_o inverts every HALF_DIV master cycles, starting from 0, which gives a period of 2*HALF_DIV cycles (12 by default).
- R4: The channel select starts at 1 (left) and inverts on every SLOT_BITS-th falling edge of bclk_o (16 by default).
- R5: adc_lr_o is always equal to dac_lr_o.
- R6: A bit index starts at 15 and decrements on each rising bclk_o edge, wrapping from 0 back to 15. dac_dat_o shows the captured sample's bit at that index.
- R7: Select 01 drives the V source and select 10 drives the U source. Each 16-bit sample is bits [17:2] of its 18-bit source input.
- R8: Select 00 or 11 passes adc_dat_i to dac_dat_o combinationally.
- R9: Both sources are captured on every cycle while the block is idle, and on the rising bclk_o edge where the index wraps to 15. Changes to a source at any other time do not affect the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Output source select |
| v_src_i | input | 18 | V source value |
| u_src_i | input | 18 | U source value |
| adc_dat_i | input | 1 | Codec ADC serial data |
| bclk_o | output | 1 | Serial bit clock |
| dac_lr_o | output | 1 | DAC channel select, 1 = left |
| adc_lr_o | output | 1 | ADC channel select, 1 = left |
| dac_dat_o | output | 1 | Codec DAC serial data |

## Verification
Two events can fall in the same clk_i cycle: a source value changing, and the word-boundary capture on the rising bit-clock edge that reloads index 15. A third case is the same source change landing mid-word. The bench changes both sources on exactly the cycle before each capture edge, and also at a spacing that does not divide the word length. Its cycle-count model of the capture point decides whether the old or the new value must appear bit by bit. The select input is also switched mid-word to confirm that the new source shows at the current index with no pipeline delay.

// File: rtl/audio_dac_pkg.sv
package audio_dac_pkg;
  typedef enum logic [1:0] {
    SEL_LOOP_A = 2'b00,
    SEL_V      = 2'b01,
    SEL_U      = 2'b10,
    SEL_LOOP_B = 2'b11
  } src_sel_e;
endpackage

// File: rtl/startup_delay.sv
module startup_delay #(
  parameter int unsigned DELAY_CYC = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic en_o
);
  localparam int unsigned CW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (!en_q) begin
      if (cnt_q == LAST) en_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o = en_q;

  a_r2_en_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  a_r2_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(cnt_q));
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int unsigned HALF_DIV  = 6,
  parameter int unsigned SLOT_BITS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic bclk_o,
  output logic lr_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned SW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [DW-1:0] DIV_LAST  = DW'(HALF_DIV - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_BITS - 1);

  logic [DW-1:0] div_q;
  logic [SW-1:0] slot_q;
  logic          bclk_q, lr_q, half_end;

  assign half_end = run_i && (div_q == DIV_LAST);
  assign rise_o   = half_end && !bclk_q;
  assign fall_o   = half_end &&  bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!run_i) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (half_end) begin
      div_q  <= '0;
      bclk_q <= !bclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  // channel select advances on falling bit-clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      lr_q   <= 1'b1;
    end else if (!run_i) begin
      slot_q <= '0;
      lr_q   <= 1'b1;
    end else if (fall_o) begin
      if (slot_q == SLOT_LAST) begin
        slot_q <= '0;
        lr_q   <= !lr_q;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign bclk_o = bclk_q;
  assign lr_o   = lr_q;

  a_r3_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !bclk_q);
  a_r3_toggle_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !half_end) |=> $stable(bclk_q));
  a_r4_lr_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !fall_o) |=> $stable(lr_q));
  a_r4_idle_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> lr_q);
endmodule

// File: rtl/dac_serializer.sv
module dac_serializer
  import audio_dac_pkg::*;
#(
  parameter int unsigned SRC_W = 18,
  parameter int unsigned SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic [1:0]       sel_i,
  input  logic [SRC_W-1:0] v_src_i,
  input  logic [SRC_W-1:0] u_src_i,
  input  logic             adc_dat_i,
  output logic             dac_dat_o
);
  localparam int unsigned IW = $clog2(SMP_W);
  localparam logic [IW-1:0] IDX_TOP = IW'(SMP_W - 1);
  localparam int unsigned DROP = SRC_W - SMP_W;

  logic [IW-1:0]    idx_q;
  logic [SMP_W-1:0] v_lat_q, u_lat_q;
  logic             word_end, load;

  assign word_end = rise_i && (idx_q == '0);
  assign load     = !run_i || word_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= IDX_TOP;
    else if (!run_i)  idx_q <= IDX_TOP;
    else if (rise_i)  idx_q <= (idx_q == '0) ? IDX_TOP : idx_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_lat_q <= '0;
      u_lat_q <= '0;
    end else if (load) begin
      v_lat_q <= v_src_i[SRC_W-1 -: SMP_W];
      u_lat_q <= u_src_i[SRC_W-1 -: SMP_W];
    end
  end

  always_comb begin
    unique case (src_sel_e'(sel_i))
      SEL_V:   dac_dat_o = v_lat_q[idx_q];
      SEL_U:   dac_dat_o = u_lat_q[idx_q];
      default: dac_dat_o = adc_dat_i;
    endcase
  end

  if (DROP > 0) begin : g_drop_note
    // low source bits are discarded by the slice above
  end

  a_r6_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !rise_i) |=> $stable(idx_q));
  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && rise_i && idx_q == '0) |=> idx_q == IDX_TOP);
  a_r9_mid_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !word_end) |=> ($stable(v_lat_q) && $stable(u_lat_q)));
endmodule

// File: rtl/audio_dac_stream.sv
module audio_dac_stream #(
  parameter int unsigned DELAY_CYC = 2000000,
  parameter int unsigned HALF_DIV  = 6,
  parameter int unsigned SLOT_BITS = 16,
  parameter int unsigned SRC_W     = 18,
  parameter int unsigned SMP_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic [SRC_W-1:0] v_src_i,
  input  logic [SRC_W-1:0] u_src_i,
  input  logic             adc_dat_i,
  output logic             bclk_o,
  output logic             dac_lr_o,
  output logic             adc_lr_o,
  output logic             dac_dat_o
);
  logic run, rise, fall, lr;

  startup_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_o  (run)
  );

  sclk_gen #(.HALF_DIV(HALF_DIV), .SLOT_BITS(SLOT_BITS)) u_sclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .bclk_o(bclk_o),
    .lr_o  (lr),
    .rise_o(rise),
    .fall_o(fall)
  );

  dac_serializer #(.SRC_W(SRC_W), .SMP_W(SMP_W)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .rise_i   (rise),
    .sel_i    (sel_i),
    .v_src_i  (v_src_i),
    .u_src_i  (u_src_i),
    .adc_dat_i(adc_dat_i),
    .dac_dat_o(dac_dat_o)
  );

  assign dac_lr_o = lr;
  assign adc_lr_o = lr;

  a_r5_lr_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_lr_o == adc_lr_o);
  a_r3_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise && fall));
endmodule

// File: tb/audio_dac_stream_tb.sv
module audio_dac_stream_tb;
  localparam int D = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  sel_i = 2'b01;
  logic [17:0] v_src_i = 18'h2A5C3;
  logic [17:0] u_src_i = 18'h1F00D;
  logic        adc_dat_i = 1'b0;
  logic        bclk_o, dac_lr_o, adc_lr_o, dac_dat_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  audio_dac_stream #(.DELAY_CYC(D)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i),
    .v_src_i(v_src_i), .u_src_i(u_src_i), .adc_dat_i(adc_dat_i),
    .bclk_o(bclk_o), .dac_lr_o(dac_lr_o), .adc_lr_o(adc_lr_o),
    .dac_dat_o(dac_dat_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  int n = 0;
  logic [15:0] mv = '0, mu = '0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit is_cap_edge(input int e);
    int m;
    if (e <= D) return 1'b1;
    m = e - D;
    return (m % 12 == 6) && (((m + 6) / 12) % 16 == 0);
  endfunction

  task automatic model_edge();
    n++;
    if (is_cap_edge(n)) begin
      mv = v_src_i[17:2];
      mu = u_src_i[17:2];
    end
  endtask

  task automatic check_all();
    int m, f, r, idx, exp_dac;
    m   = (n <= D) ? 0 : n - D;
    f   = m / 12;
    r   = (m + 6) / 12;
    idx = 15 - (r % 16);
    chk((n <= D) ? "R2 bclk idle" : "R3 bclk", bclk_o, (m / 6) % 2);
    chk((n <= D) ? "R2 lr idle" : "R4 lr", dac_lr_o, ((f / 16) % 2) == 0);
    chk("R5 adc_lr", adc_lr_o, dac_lr_o);
    if (sel_i == 2'b01)      exp_dac = mv[idx];
    else if (sel_i == 2'b10) exp_dac = mu[idx];
    else                     exp_dac = adc_dat_i;
    chk((sel_i == 2'b01 || sel_i == 2'b10) ? "R6 R7 R9 dac" : "R8 loop",
        dac_dat_o, exp_dac);
  endtask

  task automatic reset_phase();
    rst_ni = 1'b0;
    sel_i  = 2'b01;
    n = 0; mv = '0; mu = '0;
    repeat (3) begin
      @(negedge clk_i);
      chk("R1 bclk", bclk_o, 0);
      chk("R1 lr", dac_lr_o, 1);
      chk("R1 adc_lr", adc_lr_o, 1);
      chk("R1 dac", dac_dat_o, 0);
    end
    sel_i = 2'b10;
    #1 chk("R1 dac U", dac_dat_o, 0);
    sel_i = 2'b01;
    rst_ni = 1'b1;
  endtask

  task automatic run_phase(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk_i);
      model_edge();
      @(negedge clk_i);
      check_all();
      // stimulus for the next edge
      if (n < 600)       sel_i = 2'b01;
      else if (n < 1200) sel_i = 2'b10;
      else if (n < 1500) sel_i = 2'b00;
      else if (n < 1800) sel_i = 2'b11;
      else               sel_i = (n % 250 < 125) ? 2'b01 : 2'b10;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      adc_dat_i = lfsr[0];
      if (is_cap_edge(n + 1) || (n % 37 == 0)) begin
        v_src_i = v_src_i * 18'd1103 + 18'd12345;
        u_src_i = u_src_i * 18'd2731 + 18'd9011;
      end
      #1;
      if (sel_i == 2'b00 || sel_i == 2'b11)
        chk("R8 loop immediate", dac_dat_o, adc_dat_i);
    end
  endtask

  initial begin
    reset_phase();
    run_phase(2400);
    @(negedge clk_i);
    reset_phase();
    run_phase(500);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule